// File: doc/BRIEF.md
# Multi-Line Receive Silo

This block is the shared receive queue of a sixteen-line serial multiplexer. Each receiver pushes a finished character into it with a single strobe, together with the number of its line and its parity and framing error indications. All lines share one first-in first-out store. A host drains the store through one 16-bit read word. The word shows the head entry, and a read strobe removes that entry.

The read word is laid out so that software can poll it by testing its sign bit. Bit 15 is set whenever the word carries a character. Bits 11:8 give the line the character came from, and bits 7:0 give the character itself. Bits 12, 13 and 14 flag a parity error, a framing error (a break) and a lost character. A control word holds two interrupt enables and a master-clear command. A separate alarm level sets how full the queue must be before the storage interrupt is raised.

Top module: `rx_silo_top`

## Requirements
- R1: When the queue is non-empty, `rd_word` shows the oldest entry. Bit 15 is 1, bit 14 is the lost-character flag, bit 13 is the framing error, bit 12 is the parity error, bits 11:8 are the line number and bits 7:0 are the character.
- R2: Entries come out in the order they were accepted, whatever their lines. Each `rd_en` pulse on a non-empty queue removes exactly one entry.
- R3: When the queue is empty, `rd_word` is all zeros. An `rd_en` pulse on an empty queue changes nothing.
- R4: The queue holds DEPTH (64) entries. A push that arrives when the queue is full and no pop happens in the same cycle is discarded. The next entry that is accepted carries bit 14 set. Entries accepted without an earlier discard carry bit 14 clear.
- R5: A push in the same cycle as a pop on a full queue is accepted, and it does not set the lost-character flag.
- R6: Bit 7 of `csr_rdata` is 1 exactly when the queue is non-empty. Bit 6 is the receive interrupt enable, written through `csr_wdata[6]`. `rx_irq` equals bit 7 AND bit 6.
- R7: Bit 14 of `csr_rdata` is 1 exactly when the occupancy is non-zero and at or above the alarm level. Bit 12 is the storage interrupt enable, written through `csr_wdata[12]`. `store_irq` equals bit 14 AND bit 12, and it drops as soon as the occupancy falls below the alarm level.
- R8: The alarm level resets to 16. It is written through `alarm_wr`/`alarm_wdata` and read back on `alarm_rdata`.
- R9: A control write with bit 11 set empties the queue and clears both enables and any pending lost-character flag. The other data bits of that write are ignored, the alarm level is kept, and bit 11 always reads back as 0.
- R10: After reset the queue is empty, `rd_word` and `csr_rdata` are zero, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | A receiver has a finished character |
| push_line | input | 4 | Source line of the character |
| push_data | input | 8 | Received character |
| push_perr | input | 1 | Parity error on this character |
| push_ferr | input | 1 | Framing error (break) on this character |
| rd_en | input | 1 | Pop the head entry |
| rd_word | output | 16 | Head entry in read-word format |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control write data (bit 6, bit 11, bit 12 used) |
| csr_rdata | output | 16 | Control/status read value |
| alarm_wr | input | 1 | Alarm level write strobe |
| alarm_wdata | input | 7 | New alarm level |
| alarm_rdata | output | 7 | Current alarm level |
| rx_irq | output | 1 | Receive interrupt request |
| store_irq | output | 1 | Storage interrupt request |

## Verification
The hardest states to reach are the ones around a full queue. To exercise them, the bench fills all 64 slots with a sweep over every line and error combination. It then presses on that boundary in three ways: a push together with a pop, a push that is discarded, and the flagged entry that follows the discard. Discarded pushes are only visible later, through the flag on a later entry, so the bench drains the whole queue and compares each word with its own reference queue. The alarm comparison is then swept over every level from 0 to 64 at every occupancy on the way up and down.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

   // Read word bit positions (software decodes these)
   localparam int unsigned VALID_BIT = 15;
   localparam int unsigned LOST_BIT  = 14;
   localparam int unsigned FERR_BIT  = 13;
   localparam int unsigned PERR_BIT  = 12;
   localparam int unsigned LINE_LSB  = 8;
   localparam int unsigned CHAR_MAX  = 8;
   localparam int unsigned LINE_MAX  = 4;

   // Control/status bit positions
   localparam int unsigned CS_RX_EN   = 6;
   localparam int unsigned CS_RX_STAT = 7;
   localparam int unsigned CS_MCLR    = 11;
   localparam int unsigned CS_STO_EN  = 12;
   localparam int unsigned CS_STO_ST  = 14;

   typedef struct packed {
      logic                lost;
      logic                ferr;
      logic                perr;
      logic [LINE_MAX-1:0] line;
      logic [CHAR_MAX-1:0] ch;
   } silo_entry_t;

   localparam int unsigned ENTRY_W = $bits(silo_entry_t);

   function automatic logic [15:0] entry_to_word(input silo_entry_t e, input logic vld);
      logic [15:0] w;
      w = '0;
      if (vld) begin
         w[VALID_BIT] = 1'b1;
         w[LOST_BIT]  = e.lost;
         w[FERR_BIT]  = e.ferr;
         w[PERR_BIT]  = e.perr;
         w[LINE_LSB +: LINE_MAX] = e.line;
         w[0 +: CHAR_MAX] = e.ch;
      end
      return w;
   endfunction

endpackage

// File: rtl/rx_silo_store.sv
module rx_silo_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 15,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   localparam bit POW2 = ((1 << PW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wp_inc, rp_inc;

   generate
      if (POW2) begin : g_wrap_free
         always_comb begin
            wp_inc = wr_ptr + PW'(1);
            rp_inc = rd_ptr + PW'(1);
         end
      end else begin : g_wrap_cmp
         always_comb begin
            wp_inc = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            rp_inc = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en && !clr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wp_inc;
         if (rd_en) rd_ptr <= rp_inc;
         case ({wr_en, rd_en})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr];
   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);

endmodule

// File: rtl/rx_silo_pack.sv
module rx_silo_pack
   import rx_silo_pkg::*;
#(
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned LINE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push_valid,
   input  logic [LINE_W-1:0] push_line,
   input  logic [CHAR_W-1:0] push_data,
   input  logic              push_perr,
   input  logic              push_ferr,
   input  logic              full,
   input  logic              pop,
   output logic              wr_en,
   output silo_entry_t       wr_entry
);

   logic lost_pend;
   logic drop;

   assign wr_en = push_valid && !clr && (!full || pop);
   assign drop  = push_valid && !clr && full && !pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lost_pend <= 1'b0;
      else if (clr)   lost_pend <= 1'b0;
      else if (wr_en) lost_pend <= 1'b0;
      else if (drop)  lost_pend <= 1'b1;
   end

   always_comb begin
      wr_entry      = '0;
      wr_entry.lost = lost_pend;
      wr_entry.ferr = push_ferr;
      wr_entry.perr = push_perr;
      wr_entry.line = LINE_MAX'(push_line);
      wr_entry.ch   = CHAR_MAX'(push_data);
   end

endmodule

// File: rtl/rx_silo_ctl.sv
module rx_silo_ctl
   import rx_silo_pkg::*;
#(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned ALARM_RST = 16,
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_wr,
   input  logic [15:0]   csr_wdata,
   input  logic          alarm_wr,
   input  logic [CW-1:0] alarm_wdata,
   input  logic [CW-1:0] count,
   input  logic          empty,
   output logic          mclr,
   output logic [15:0]   csr_rdata,
   output logic [CW-1:0] alarm_rdata,
   output logic          rx_irq,
   output logic          store_irq
);

   logic          rx_en, sto_en;
   logic [CW-1:0] alarm_lvl;
   logic          rx_stat, sto_stat;

   assign mclr = csr_wr && csr_wdata[CS_MCLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en  <= 1'b0;
         sto_en <= 1'b0;
      end else if (mclr) begin
         rx_en  <= 1'b0;
         sto_en <= 1'b0;
      end else if (csr_wr) begin
         rx_en  <= csr_wdata[CS_RX_EN];
         sto_en <= csr_wdata[CS_STO_EN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alarm_lvl <= CW'(ALARM_RST);
      else if (alarm_wr) alarm_lvl <= alarm_wdata;
   end

   assign rx_stat  = !empty;
   assign sto_stat = !empty && (count >= alarm_lvl);

   always_comb begin
      csr_rdata             = '0;
      csr_rdata[CS_RX_EN]   = rx_en;
      csr_rdata[CS_RX_STAT] = rx_stat;
      csr_rdata[CS_STO_EN]  = sto_en;
      csr_rdata[CS_STO_ST]  = sto_stat;
   end

   assign alarm_rdata = alarm_lvl;
   assign rx_irq      = rx_stat && rx_en;
   assign store_irq   = sto_stat && sto_en;

endmodule

// File: rtl/rx_silo_top.sv
module rx_silo_top
   import rx_silo_pkg::*;
#(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned LINES     = 16,
   parameter int unsigned CHAR_W    = 8,
   parameter int unsigned ALARM_RST = 16,
   localparam int unsigned LINE_W   = $clog2(LINES),
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [LINE_W-1:0] push_line,
   input  logic [CHAR_W-1:0] push_data,
   input  logic              push_perr,
   input  logic              push_ferr,
   input  logic              rd_en,
   output logic [15:0]       rd_word,
   input  logic              csr_wr,
   input  logic [15:0]       csr_wdata,
   output logic [15:0]       csr_rdata,
   input  logic              alarm_wr,
   input  logic [CW-1:0]     alarm_wdata,
   output logic [CW-1:0]     alarm_rdata,
   output logic              rx_irq,
   output logic              store_irq
);

   generate
      if (LINES < 2 || LINES > (1 << LINE_MAX)) begin : g_bad_lines
         $error("rx_silo_top: LINES must be 2..16");
      end
      if (CHAR_W < 5 || CHAR_W > CHAR_MAX) begin : g_bad_char
         $error("rx_silo_top: CHAR_W must be 5..8");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_silo_top: DEPTH must be at least 2");
      end
      if (ALARM_RST > DEPTH) begin : g_bad_alarm
         $error("rx_silo_top: ALARM_RST exceeds DEPTH");
      end
   endgenerate

   logic          mclr;
   logic          wr_en, pop, full, empty;
   logic [CW-1:0] occ;
   silo_entry_t   wr_entry, head;
   logic [ENTRY_W-1:0] head_bits;

   assign pop = rd_en && !empty && !mclr;

   rx_silo_ctl #(
      .DEPTH     (DEPTH),
      .ALARM_RST (ALARM_RST)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_wr      (csr_wr),
      .csr_wdata   (csr_wdata),
      .alarm_wr    (alarm_wr),
      .alarm_wdata (alarm_wdata),
      .count       (occ),
      .empty       (empty),
      .mclr        (mclr),
      .csr_rdata   (csr_rdata),
      .alarm_rdata (alarm_rdata),
      .rx_irq      (rx_irq),
      .store_irq   (store_irq)
   );

   rx_silo_pack #(
      .CHAR_W (CHAR_W),
      .LINE_W (LINE_W)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (mclr),
      .push_valid (push_valid),
      .push_line  (push_line),
      .push_data  (push_data),
      .push_perr  (push_perr),
      .push_ferr  (push_ferr),
      .full       (full),
      .pop        (pop),
      .wr_en      (wr_en),
      .wr_entry   (wr_entry)
   );

   rx_silo_store #(
      .DEPTH (DEPTH),
      .W     (ENTRY_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mclr),
      .wr_en   (wr_en),
      .wr_data (wr_entry),
      .rd_en   (pop),
      .rd_data (head_bits),
      .count   (occ),
      .full    (full),
      .empty   (empty)
   );

   assign head    = silo_entry_t'(head_bits);
   assign rd_word = entry_to_word(head, !empty);

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned LINE_W = 4,
   parameter int unsigned CHAR_W = 8,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_valid,
   input logic [LINE_W-1:0] push_line,
   input logic [CHAR_W-1:0] push_data,
   input logic              rd_en,
   input logic [15:0]       rd_word,
   input logic              csr_wr,
   input logic [15:0]       csr_wdata,
   input logic [15:0]       csr_rdata,
   input logic              rx_irq,
   input logic              store_irq,
   input logic [CW-1:0]     occ
);

   AST_PUSH_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_word[15] && push_valid && !(csr_wr && csr_wdata[11])) |=>
      (rd_word[15] && rd_word[11:8] == 4'($past(push_line)) &&
       rd_word[CHAR_W-1:0] == $past(push_data))); // R1

   AST_EMPTY_POP_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_word[15] && rd_en && !push_valid) |=> (rd_word == 16'h0)); // R3

   AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (occ <= CW'(DEPTH))); // R4

   AST_RX_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (csr_rdata[6] && rd_word[15])); // R6

   AST_RX_STAT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[7] == rd_word[15])); // R6

   AST_STORE_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      store_irq |-> (csr_rdata[12] && csr_rdata[14])); // R7

   AST_MCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[11]) |=> (rd_word == 16'h0 && !rx_irq && !store_irq && occ == '0)); // R9

endmodule

bind rx_silo_top rx_silo_chk #(
   .DEPTH  (DEPTH),
   .LINE_W (LINE_W),
   .CHAR_W (CHAR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .push_line  (push_line),
   .push_data  (push_data),
   .rd_en      (rd_en),
   .rd_word    (rd_word),
   .csr_wr     (csr_wr),
   .csr_wdata  (csr_wdata),
   .csr_rdata  (csr_rdata),
   .rx_irq     (rx_irq),
   .store_irq  (store_irq),
   .occ        (occ)
);

// File: tb/tb_rx_silo_top.sv
module tb_rx_silo_top;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [3:0]  push_line = '0;
   logic [7:0]  push_data = '0;
   logic        push_perr = 1'b0;
   logic        push_ferr = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_word;
   logic        csr_wr = 1'b0;
   logic [15:0] csr_wdata = '0;
   logic [15:0] csr_rdata;
   logic        alarm_wr = 1'b0;
   logic [6:0]  alarm_wdata = '0;
   logic [6:0]  alarm_rdata;
   logic        rx_irq, store_irq;

   always #2 clk = ~clk;

   rx_silo_top dut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_line(push_line), .push_data(push_data),
      .push_perr(push_perr), .push_ferr(push_ferr),
      .rd_en(rd_en), .rd_word(rd_word),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata), .alarm_rdata(alarm_rdata),
      .rx_irq(rx_irq), .store_irq(store_irq)
   );

   int checks = 0;
   int fails  = 0;

   // reference model
   logic [15:0] mq[$];
   logic        m_pend = 1'b0;
   logic        m_rx_en = 1'b0;
   logic        m_sto_en = 1'b0;
   logic [6:0]  m_alarm = 7'd16;

   task automatic expect16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      logic [15:0] ew, ec;
      logic        st;
      ew = (mq.size() != 0) ? mq[0] : 16'h0;
      st = (mq.size() != 0) && (mq.size() >= int'(m_alarm));
      ec = '0;
      ec[6]  = m_rx_en;
      ec[7]  = (mq.size() != 0);
      ec[12] = m_sto_en;
      ec[14] = st;
      expect16(tag, rd_word, ew);
      expect16("R6/R7 csr", csr_rdata, ec);
      expect16("R6 rx_irq", {15'h0, rx_irq}, {15'h0, ec[7] & m_rx_en});
      expect16("R7 store_irq", {15'h0, store_irq}, {15'h0, st & m_sto_en});
      expect16("R8 alarm", {9'h0, alarm_rdata}, {9'h0, m_alarm});
   endtask

   task automatic cyc(input logic pv, input logic [3:0] ln, input logic [7:0] d,
                      input logic pe, input logic fe, input logic rd,
                      input logic cw, input logic [15:0] cwd,
                      input logic aw, input logic [6:0] awd, input string tag);
      logic was_full, popm;
      @(negedge clk);
      push_valid = pv; push_line = ln; push_data = d; push_perr = pe; push_ferr = fe;
      rd_en = rd; csr_wr = cw; csr_wdata = cwd; alarm_wr = aw; alarm_wdata = awd;
      @(posedge clk);
      #1;
      push_valid = 1'b0; rd_en = 1'b0; csr_wr = 1'b0; alarm_wr = 1'b0;
      if (cw && cwd[11]) begin
         mq.delete(); m_pend = 1'b0; m_rx_en = 1'b0; m_sto_en = 1'b0;
      end else begin
         was_full = (mq.size() == DEPTH);
         popm = rd && (mq.size() != 0);
         if (popm) void'(mq.pop_front());
         if (pv) begin
            if (!was_full || popm) begin
               mq.push_back({1'b1, m_pend, fe, pe, ln, d});
               m_pend = 1'b0;
            end else m_pend = 1'b1;
         end
         if (cw) begin m_rx_en = cwd[6]; m_sto_en = cwd[12]; end
      end
      if (aw) m_alarm = awd;
      check_state(tag);
   endtask

   task automatic push(input logic [3:0] ln, input logic [7:0] d, input logic pe, input logic fe, input string tag);
      cyc(1'b1, ln, d, pe, fe, 1'b0, 1'b0, 16'h0, 1'b0, 7'h0, tag);
   endtask

   task automatic pop(input string tag);
      cyc(1'b0, 4'h0, 8'h0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 7'h0, tag);
   endtask

   task automatic csr(input logic [15:0] v, input string tag);
      cyc(1'b0, 4'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b1, v, 1'b0, 7'h0, tag);
   endtask

   task automatic set_alarm(input logic [6:0] v);
      cyc(1'b0, 4'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1, v, "R8 alarm write");
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_state("R10 reset");

      // R3: pop on empty
      pop("R3 empty pop");
      pop("R3 empty pop again");

      // enable both interrupts
      csr(16'h1040, "R6 enable write");

      // R1/R4: fill with every line and error combination
      for (int ln = 0; ln < 16; ln++) begin
         for (int e = 0; e < 4; e++) begin
            push(4'(ln), 8'(ln * 16 + e * 37 + 3), e[0], e[1], "R1 fill sweep");
         end
      end

      // R5: push and pop together while full
      cyc(1'b1, 4'hA, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 7'h0, "R5 push+pop on full");

      // R4: discarded pushes, then flagged entry
      push(4'h3, 8'hEE, 1'b0, 1'b0, "R4 drop on full");
      push(4'h4, 8'hEF, 1'b0, 1'b0, "R4 second drop");
      pop("R2 pop after drop");
      push(4'h7, 8'h77, 1'b0, 1'b1, "R4 flagged entry");
      push(4'h8, 8'h88, 1'b0, 1'b0, "R4 drop again");

      // R2: drain in order
      for (int i = 0; i < DEPTH; i++) pop("R2 drain order");
      pop("R3 pop when drained");
      push(4'h1, 8'h11, 1'b0, 1'b0, "R4 flag after second drop");
      pop("R2 final pop");

      // R7: alarm sweep over all levels and occupancies
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
         set_alarm(7'(lvl));
         for (int k = 0; k < DEPTH; k++) push(4'(k), 8'(k + lvl), 1'b0, 1'b0, "R7 alarm fill");
         for (int k = 0; k < DEPTH; k++) pop("R7 alarm drain");
      end

      // R9: master clear
      set_alarm(7'd5);
      csr(16'h1040, "R6 enable write");
      for (int k = 0; k < DEPTH; k++) push(4'(k), 8'(k), 1'b1, 1'b1, "R9 prefill");
      push(4'h2, 8'h22, 1'b0, 1'b0, "R9 drop before clear");
      csr(16'hFFFF, "R9 master clear");
      push(4'h9, 8'h99, 1'b0, 1'b0, "R9 no lost flag after clear");
      csr(16'h1040, "R9 re-enable");
      pop("R9 pop");
      check_state("R9 final");

      finish_run();
   end

endmodule